// File: doc/BRIEF.md
# Chroma-from-Luma Sample Predictor

This block turns zero-mean luma AC values into chroma prediction samples. Each beat carries `LANES` signed AC values from one row of a block, together with a signed Q3 scaling factor, a DC chroma level, a bit-depth code and a block-width code. Every lane scales its AC value by the factor, adds the DC level and clamps the sum to the legal pixel range for the selected depth. Rows of any supported width are streamed as consecutive beats, one beat per clock, with no stall.

The signed product is formed on magnitudes: the absolute AC value is multiplied by the absolute factor, rounded at the Q3 boundary and saturated, and the sign is then put back from the exclusive-or of the two operand sign bits. Rounding is therefore symmetric about zero. Three register stages separate input from output: magnitude and sign capture, multiply and round, then sign restore, DC add and clamp. Every per-beat setting travels down the pipeline with its own beat.

Top module: `cfl_chroma_pred`

## Requirements
- R1: `out_valid` rises exactly three clock edges after a beat is presented with `in_valid` high; consecutive valid beats give consecutive valid outputs, one per beat.
- R2: The lane magnitude is (|ac|·|alpha| + 32) >> 6, saturated to 32767; an AC value of -32768 counts as magnitude 32768 and an alpha of -128 as magnitude 128.
- R3: The scaled value is negative exactly when the AC sign bit XOR the alpha sign bit is set, and is then the negation of the rounded magnitude (so +32 and -32 at alpha 1 give +1 and -1, +31 and -31 give 0).
- R4: The prediction is the signed scaled value plus the unsigned DC level, summed without wrap before clamping; with alpha zero every active lane equals the DC level clamped.
- R5: With depth code 0 (8-bit) the output is clamped to 0..255.
- R6: Depth code 1 (10-bit) clamps to 0..1023; codes 2 and 3 (12-bit) clamp to 0..4095.
- R7: Width code 0/1/2/3 selects 4/8/16/32 samples per row; lane i (input bits i*16 upward, output bits i*PIX_W upward) is active when i is below the width, and inactive lanes output zero.
- R8: While `out_valid` is low, all of `out_pix` is zero.
- R9: A synchronous reset clears `out_valid` and `out_pix`; beats already in the pipeline are discarded and never appear.
- R10: Alpha, DC, depth and width are taken per beat; back-to-back beats with different settings each get their own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat present on the inputs |
| in_ac | input | LANES*AC_W | Signed AC values, lane i at bits i*AC_W |
| in_alpha | input | ALPHA_W | Signed Q3 scaling factor |
| in_dc | input | PIX_W | Unsigned DC chroma level |
| in_depth | input | 2 | Bit depth: 0=8, 1=10, 2 or 3=12 |
| in_wcode | input | 2 | Block width: 0=4, 1=8, 2=16, 3=32 |
| out_valid | output | 1 | Prediction beat present |
| out_pix | output | LANES*PIX_W | Clamped chroma samples, lane i at bits i*PIX_W |

## Verification
The interesting collision is the multiply saturation and the final clamp landing on the same beat, with neighbouring lanes clamping at opposite ends. The bench provokes it with AC values of -32768 and 32767 against an alpha of -128 at high DC, so one lane saturates its magnitude and then clips to the top while its neighbour goes far negative and clips to zero. A scoreboard model computes each lane from the rules above and the monitor compares whole output beats, so a wrong saturation width, sign or clamp bound on either path shows up as a miscompare.

// File: rtl/cfl_pkg.sv
package cfl_pkg;

  typedef enum logic [1:0] {
    DEPTH_8  = 2'd0,
    DEPTH_10 = 2'd1,
    DEPTH_12 = 2'd2,
    DEPTH_12B = 2'd3
  } depth_e;

  // Largest legal pixel value for a depth code.
  function automatic logic [15:0] pix_max(input logic [1:0] d);
    case (d)
      DEPTH_8:  pix_max = 16'd255;
      DEPTH_10: pix_max = 16'd1023;
      default:  pix_max = 16'd4095;
    endcase
  endfunction

  // Samples per row for a width code.
  function automatic int unsigned row_width(input logic [1:0] w);
    row_width = 32'd4 << w;
  endfunction

endpackage

// File: rtl/cfl_ctrl.sv
module cfl_ctrl #(
  parameter int LANES   = 8,
  parameter int ALPHA_W = 8,
  parameter int PIX_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ALPHA_W-1:0] in_alpha,
  input  logic [PIX_W-1:0]   in_dc,
  input  logic [1:0]         in_depth,
  input  logic [1:0]         in_wcode,
  output logic [ALPHA_W-1:0] s1_amag,
  output logic               s2_valid,
  output logic [PIX_W-1:0]   s2_dc,
  output logic [PIX_W-1:0]   s2_max,
  output logic [LANES-1:0]   s2_mask,
  output logic               s3_valid
);
  import cfl_pkg::*;

  logic             s1_valid;
  logic [PIX_W-1:0] s1_dc;
  logic [1:0]       s1_depth;
  logic [1:0]       s1_wcode;
  logic [15:0]      max_full;
  logic [LANES-1:0] mask_next;

  always_comb begin
    max_full = pix_max(s1_depth);
    for (int i = 0; i < LANES; i++)
      mask_next[i] = (i < row_width(s1_wcode));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_amag  <= '0;
      s1_dc    <= '0;
      s1_depth <= '0;
      s1_wcode <= '0;
      s2_valid <= 1'b0;
      s2_dc    <= '0;
      s2_max   <= '0;
      s2_mask  <= '0;
      s3_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      s1_amag  <= in_alpha[ALPHA_W-1] ? (~in_alpha + 1'b1) : in_alpha;
      s1_dc    <= in_dc;
      s1_depth <= in_depth;
      s1_wcode <= in_wcode;
      s2_valid <= s1_valid;
      s2_dc    <= s1_dc;
      s2_max   <= max_full[PIX_W-1:0];
      s2_mask  <= mask_next;
      s3_valid <= s2_valid;
    end
  end
endmodule

// File: rtl/cfl_mag_lane.sv
module cfl_mag_lane #(
  parameter int AC_W    = 16,
  parameter int ALPHA_W = 8,
  parameter int FRAC_SH = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AC_W-1:0]    ac,
  input  logic               alpha_sign,
  input  logic [ALPHA_W-1:0] s1_amag,
  output logic [AC_W-2:0]    s2_scaled,
  output logic               s2_neg
);
  localparam int PW  = AC_W + ALPHA_W;
  localparam int SCL = AC_W - 1;

  logic [AC_W-1:0] s1_mag;
  logic            s1_neg;
  logic [PW:0]     rounded;
  logic [PW:0]     shifted;
  logic [SCL-1:0]  sat_val;

  always_comb begin
    rounded = ({1'b0, {ALPHA_W{1'b0}}, s1_mag} * {{(AC_W+1){1'b0}}, s1_amag})
            + (PW+1)'(1 << (FRAC_SH - 1));
    shifted = rounded >> FRAC_SH;
    if (shifted > (PW+1)'({SCL{1'b1}}))
      sat_val = {SCL{1'b1}};
    else
      sat_val = shifted[SCL-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_mag    <= '0;
      s1_neg    <= 1'b0;
      s2_scaled <= '0;
      s2_neg    <= 1'b0;
    end else begin
      s1_mag    <= ac[AC_W-1] ? (~ac + 1'b1) : ac;
      s1_neg    <= ac[AC_W-1] ^ alpha_sign;
      s2_scaled <= sat_val;
      s2_neg    <= s1_neg;
    end
  end
endmodule

// File: rtl/cfl_out_lane.sv
module cfl_out_lane #(
  parameter int AC_W  = 16,
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s2_valid,
  input  logic             lane_en,
  input  logic [AC_W-2:0]  s2_scaled,
  input  logic             s2_neg,
  input  logic [PIX_W-1:0] s2_dc,
  input  logic [PIX_W-1:0] s2_max,
  output logic [PIX_W-1:0] pix
);
  localparam int SUM_W = AC_W + 1;

  logic [SUM_W-1:0] ext;
  logic [SUM_W-1:0] smask;
  logic [SUM_W-1:0] signed_v;
  logic [SUM_W-1:0] sum;
  logic [PIX_W-1:0] clamped;

  always_comb begin
    ext      = {2'b00, s2_scaled};
    smask    = {SUM_W{s2_neg}};
    signed_v = (ext + smask) ^ smask;
    sum      = signed_v + {{(SUM_W-PIX_W){1'b0}}, s2_dc};
    if (sum[SUM_W-1])
      clamped = '0;
    else if (sum[SUM_W-2:0] > {{(SUM_W-1-PIX_W){1'b0}}, s2_max})
      clamped = s2_max;
    else
      clamped = sum[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      pix <= '0;
    else
      pix <= (s2_valid && lane_en) ? clamped : '0;
  end
endmodule

// File: rtl/cfl_chroma_pred.sv
module cfl_chroma_pred #(
  parameter int LANES   = 8,
  parameter int AC_W    = 16,
  parameter int ALPHA_W = 8,
  parameter int PIX_W   = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES*AC_W-1:0]  in_ac,
  input  logic [ALPHA_W-1:0]     in_alpha,
  input  logic [PIX_W-1:0]       in_dc,
  input  logic [1:0]             in_depth,
  input  logic [1:0]             in_wcode,
  output logic                   out_valid,
  output logic [LANES*PIX_W-1:0] out_pix
);
  localparam int FRAC_SH = 6;

  logic [ALPHA_W-1:0] s1_amag;
  logic               s2_valid;
  logic [PIX_W-1:0]   s2_dc;
  logic [PIX_W-1:0]   s2_max;
  logic [LANES-1:0]   s2_mask;

  cfl_ctrl #(.LANES(LANES), .ALPHA_W(ALPHA_W), .PIX_W(PIX_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_alpha(in_alpha),
    .in_dc(in_dc), .in_depth(in_depth), .in_wcode(in_wcode),
    .s1_amag(s1_amag), .s2_valid(s2_valid), .s2_dc(s2_dc),
    .s2_max(s2_max), .s2_mask(s2_mask), .s3_valid(out_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [AC_W-2:0] scaled;
    logic            neg;

    cfl_mag_lane #(.AC_W(AC_W), .ALPHA_W(ALPHA_W), .FRAC_SH(FRAC_SH)) u_mag (
      .clk(clk), .rst(rst), .ac(in_ac[g*AC_W +: AC_W]),
      .alpha_sign(in_alpha[ALPHA_W-1]), .s1_amag(s1_amag),
      .s2_scaled(scaled), .s2_neg(neg)
    );

    cfl_out_lane #(.AC_W(AC_W), .PIX_W(PIX_W)) u_out (
      .clk(clk), .rst(rst), .s2_valid(s2_valid), .lane_en(s2_mask[g]),
      .s2_scaled(scaled), .s2_neg(neg), .s2_dc(s2_dc), .s2_max(s2_max),
      .pix(out_pix[g*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/cfl_pred_chk.sv
module cfl_pred_chk #(
  parameter int LANES   = 8,
  parameter int AC_W    = 16,
  parameter int ALPHA_W = 8,
  parameter int PIX_W   = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [LANES*AC_W-1:0]  in_ac,
  input logic [ALPHA_W-1:0]     in_alpha,
  input logic [PIX_W-1:0]       in_dc,
  input logic [1:0]             in_depth,
  input logic [1:0]             in_wcode,
  input logic                   out_valid,
  input logic [LANES*PIX_W-1:0] out_pix
);
  import cfl_pkg::*;

  logic [1:0]         warm;
  logic [2:0]         v_d;
  logic [1:0]         dep_d [3];
  logic [1:0]         w_d   [3];
  logic [ALPHA_W-1:0] a_d   [3];
  logic [PIX_W-1:0]   dc_d  [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      warm <= '0;
      v_d  <= '0;
      for (int i = 0; i < 3; i++) begin
        dep_d[i] <= '0; w_d[i] <= '0; a_d[i] <= '0; dc_d[i] <= '0;
      end
    end else begin
      if (warm != 2'd3) warm <= warm + 2'd1;
      v_d      <= {v_d[1:0], in_valid};
      dep_d[0] <= in_depth; w_d[0] <= in_wcode; a_d[0] <= in_alpha; dc_d[0] <= in_dc;
      for (int i = 1; i < 3; i++) begin
        dep_d[i] <= dep_d[i-1]; w_d[i] <= w_d[i-1];
        a_d[i]   <= a_d[i-1];   dc_d[i] <= dc_d[i-1];
      end
    end
  end

  logic        range_ok, mask_ok, flat_ok;
  logic [15:0] mx;
  logic [15:0] dc_cl;

  always_comb begin
    mx    = pix_max(dep_d[2]);
    dc_cl = ({4'd0, dc_d[2]} > mx) ? mx : {4'd0, dc_d[2]};
    range_ok = 1'b1;
    mask_ok  = 1'b1;
    flat_ok  = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if ({4'd0, out_pix[i*PIX_W +: PIX_W]} > mx) range_ok = 1'b0;
      if (i >= row_width(w_d[2])) begin
        if (out_pix[i*PIX_W +: PIX_W] != '0) mask_ok = 1'b0;
      end else if ({4'd0, out_pix[i*PIX_W +: PIX_W]} != dc_cl) begin
        flat_ok = 1'b0;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == v_d[2]));

  assert_range_R6: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid) |-> range_ok);

  assert_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid) |-> mask_ok);

  assert_flat_R4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && out_valid && a_d[2] == '0) |-> flat_ok);

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !out_valid) |-> (out_pix == '0));

  assert_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_pix == '0));
endmodule

bind cfl_chroma_pred cfl_pred_chk #(
  .LANES(LANES), .AC_W(AC_W), .ALPHA_W(ALPHA_W), .PIX_W(PIX_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ac(in_ac),
  .in_alpha(in_alpha), .in_dc(in_dc), .in_depth(in_depth),
  .in_wcode(in_wcode), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/tb_cfl_chroma_pred.sv
module tb_cfl_chroma_pred;
  localparam int LANES = 8;
  localparam int AC_W = 16;
  localparam int ALPHA_W = 8;
  localparam int PIX_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [LANES*AC_W-1:0] in_ac = '0;
  logic [ALPHA_W-1:0] in_alpha = '0;
  logic [PIX_W-1:0] in_dc = '0;
  logic [1:0] in_depth = '0;
  logic [1:0] in_wcode = '0;
  logic out_valid;
  logic [LANES*PIX_W-1:0] out_pix;

  always #2.5 clk = ~clk;

  cfl_chroma_pred #(.LANES(LANES), .AC_W(AC_W), .ALPHA_W(ALPHA_W), .PIX_W(PIX_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ac(in_ac), .in_alpha(in_alpha),
    .in_dc(in_dc), .in_depth(in_depth), .in_wcode(in_wcode),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  int checks = 0;
  int fails = 0;
  logic [LANES*PIX_W-1:0] exp_q[$];
  string tag_q[$];

  function automatic int model(int ac, int al, int dc, int depth, bit act);
    int m, a, mx, v;
    longint p;
    if (!act) return 0;
    m = (ac < 0) ? -ac : ac;
    a = (al < 0) ? -al : al;
    p = (longint'(m) * a + 32) >>> 6;
    if (p > 32767) p = 32767;
    v = ((ac < 0) != (al < 0)) ? -int'(p) : int'(p);
    v = v + dc;
    mx = (depth == 0) ? 255 : (depth == 1) ? 1023 : 4095;
    if (v < 0) v = 0;
    if (v > mx) v = mx;
    return v;
  endfunction

  task automatic send(input int acv [LANES], input int al, input int dc,
                      input int depth, input int wc, input string tag);
    logic [LANES*PIX_W-1:0] e;
    @(negedge clk);
    for (int i = 0; i < LANES; i++) begin
      in_ac[i*AC_W +: AC_W] = AC_W'(acv[i]);
      e[i*PIX_W +: PIX_W] = PIX_W'(model(acv[i], al, dc, depth, i < (4 << wc)));
    end
    in_alpha = ALPHA_W'(al);
    in_dc = PIX_W'(dc);
    in_depth = 2'(depth);
    in_wcode = 2'(wc);
    in_valid = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1/R9 unexpected beat: actual %h expected none", out_pix);
        end else begin
          logic [LANES*PIX_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_pix !== e) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", t, out_pix, e);
          end
        end
      end else if (out_pix != '0) begin
        checks++;
        fails++;
        $display("FAIL R8 idle output: actual %h expected 0", out_pix);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (out_valid !== 1'b0 || out_pix !== '0) begin
      fails++;
      $display("FAIL R9 reset state: actual %b/%h expected 0/0", out_valid, out_pix);
    end
    rst = 1'b0;

    // R4: alpha zero gives flat DC
    send('{100, -200, 3000, -32768, 0, 1, -1, 77}, 0, 128, 0, 3, "R4 flat dc");
    // R2: positive ramp, alpha 1.0
    send('{0, 8, 16, 80, 800, 1000, 4000, 7996}, 8, 100, 1, 3, "R2 ramp");
    // R3: mixed signs, negative alpha
    send('{-400, 400, -1234, 1234, 5000, -5000, 17, -17}, -13, 2048, 2, 3, "R3 sign");
    // R3: symmetric rounding at alpha 1
    send('{32, -32, 31, -31, 33, -33, 95, -96}, 1, 50, 0, 3, "R3 rounding");
    // R2 + R6: magnitude saturation meets clamp in one beat
    send('{-32768, 32767, -32768, 32767, 0, 100, -100, 1}, -128, 4000, 2, 3, "R2 sat+clamp");
    // R5: 8-bit clamp both ends
    send('{2000, -2000, 100, -100, 0, 4000, -4000, 500}, 16, 200, 0, 3, "R5 clamp8");
    // R6: 10-bit and 12-bit via code 3
    send('{9000, -9000, 3000, 0, 0, 0, 0, 0}, 8, 1000, 1, 3, "R6 clamp10");
    send('{9000, -9000, 3000, 0, 0, 0, 0, 0}, 8, 1000, 3, 3, "R6 clamp12");
    // R7: width 4 masks upper lanes, width 8 and 16 fill
    send('{64, 64, 64, 64, 64, 64, 64, 64}, 8, 10, 2, 0, "R7 width4");
    send('{64, 64, 64, 64, 64, 64, 64, 64}, 8, 10, 2, 1, "R7 width8");
    send('{64, 64, 64, 64, 64, 64, 64, 64}, 8, 10, 2, 2, "R7 width16");
    idle(5);

    // R9: reset discards beats in flight
    send('{500, 500, 500, 500, 500, 500, 500, 500}, 8, 10, 2, 3, "R9 flushed");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    exp_q.delete();
    tag_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9 flush: actual %b expected 0", out_valid);
    end

    // R10 / R1: back-to-back beats with random settings, occasional gaps
    for (int n = 0; n < 200; n++) begin
      int acv [LANES];
      for (int i = 0; i < LANES; i++) acv[i] = int'($urandom_range(65535)) - 32768;
      if (n % 3 == 0)
        for (int i = 0; i < LANES; i++) acv[i] = int'($urandom_range(2047)) - 1024;
      send(acv, int'($urandom_range(255)) - 128, int'($urandom_range(4095)),
           int'($urandom_range(3)), int'($urandom_range(3)), "R10 random");
      if (n % 17 == 0) idle(int'($urandom_range(3)) + 1);
    end
    idle(8);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing beats: actual %0d pending expected 0", exp_q.size());
    end
    report();
  end
endmodule